// File: doc/BRIEF.md
# Dual-Port RAM with Byte Lanes

This block is a synchronous two-port shared memory. A left and a right port each carry a full set of controls: chip enable, read/write select, output enable, upper and lower byte selects, and a semaphore select. Each port also has an address, a write data word and a read data word. Either port can reach any word at any time. Both ports are sampled on one common clock. Each port's controls decode into separate read and write enables for the upper and lower byte lanes.

Pins that would be tri-state are modelled as three separate signals: a data input, a data output and one output enable per lane. A lane that is not driven shows zeros on its data output. An active semaphore select blocks every array access from that port. When both ports write the same lane of the same word in one cycle, the left port's data is stored. Depth and word width are parameters. `ADDR_W` = 14 gives the 16K-word configuration; the default is smaller to keep elaboration light.

Top module: `dpram_bytelane`

## Requirements
- R1: A word written by either port can be read back by either port at any address, including address 2**ADDR_W-1. Read data and lane enables appear on the clock edge after the one that samples the read request.
- R2: A port is deselected when its chip enable is high (`*_ce_n`=1) or both its byte selects are high. A deselected port writes nothing and drives no lane on the next cycle.
- R3: A write needs `ce_n`=0, `sem_n`=1 and `rw`=0. A low `ub_n` writes bits [DATA_W-1:DATA_W/2] and a low `lb_n` writes bits [DATA_W/2-1:0]. A lane whose select is high keeps its previous contents.
- R4: A read needs `ce_n`=0, `sem_n`=1, `rw`=1 and `oe_n`=0. On the next cycle, `lane_oe[1]` (upper) and `lane_oe[0]` (lower) are high exactly for the lanes whose selects were low, and those lanes carry the stored data.
- R5: With `rw`=1 and `oe_n`=1, the port drives no lane on the next cycle.
- R6: A low `sem_n` blocks both reading and writing of the array through that port.
- R7: If both ports write the same lane of the same address in one cycle, the left port's data is stored. Writes to different lanes of one word from the two ports are both kept.
- R8: A read in the same cycle as a write to the same address, from either port, returns the contents from before that write.
- R9: Any lane whose `lane_oe` bit is low shows zero on the matching `dout` bits.
- R10: After reset both ports show all `lane_oe` bits low and `dout` zero. Memory contents after reset are undefined.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Common clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| l_ce_n | input | 1 | Left chip enable, active low |
| l_rw | input | 1 | Left read (1) / write (0) |
| l_oe_n | input | 1 | Left output enable, active low |
| l_ub_n | input | 1 | Left upper byte select, active low |
| l_lb_n | input | 1 | Left lower byte select, active low |
| l_sem_n | input | 1 | Left semaphore select, active low, blocks array access |
| l_addr | input | ADDR_W | Left word address |
| l_din | input | DATA_W | Left write data |
| l_dout | output | DATA_W | Left read data |
| l_lane_oe | output | 2 | Left lane drive enables, bit 1 upper, bit 0 lower |
| r_ce_n | input | 1 | Right chip enable, active low |
| r_rw | input | 1 | Right read (1) / write (0) |
| r_oe_n | input | 1 | Right output enable, active low |
| r_ub_n | input | 1 | Right upper byte select, active low |
| r_lb_n | input | 1 | Right lower byte select, active low |
| r_sem_n | input | 1 | Right semaphore select, active low, blocks array access |
| r_addr | input | ADDR_W | Right word address |
| r_din | input | DATA_W | Right write data |
| r_dout | output | DATA_W | Right read data |
| r_lane_oe | output | 2 | Right lane drive enables, bit 1 upper, bit 0 lower |

## Verification
Two functions can fall in the same cycle: a write on each port to the same word, and a read on one port while the other port writes the word being read. Directed steps cause both cases on purpose. Both ports write one lane of a shared word with different data; then they write opposite lanes of another word; then one port reads a word while the other overwrites it. A read in a later cycle judges the stored result against a bench model that applies the left write last. The same-cycle read is judged against the contents before the write. Random traffic over a small window of addresses makes such collisions happen often, under every control combination.

// File: rtl/dpram_bytelane_pkg.sv
package dpram_bytelane_pkg;

   localparam int unsigned LANES = 2;
   localparam int unsigned LANE_HI = 1;
   localparam int unsigned LANE_LO = 0;

   typedef struct packed {
      logic [LANES-1:0] rd;
      logic [LANES-1:0] wr;
   } port_ctl_t;

endpackage

// File: rtl/dpram_port_decode.sv
module dpram_port_decode
   import dpram_bytelane_pkg::*;
(
   input  logic      ce_n,
   input  logic      rw,
   input  logic      oe_n,
   input  logic      ub_n,
   input  logic      lb_n,
   input  logic      sem_n,
   output port_ctl_t ctl
);

   logic             array_sel;
   logic [LANES-1:0] lane_sel;

   always_comb begin
      // semaphore select wins over array access
      array_sel         = !ce_n && sem_n;
      lane_sel[LANE_HI] = !ub_n;
      lane_sel[LANE_LO] = !lb_n;
      ctl.wr = (array_sel && !rw)          ? lane_sel : '0;
      ctl.rd = (array_sel && rw && !oe_n)  ? lane_sel : '0;
   end

endmodule

// File: rtl/dpram_lane_bank.sv
module dpram_lane_bank #(
   parameter int unsigned ADDR_W = 10,
   parameter int unsigned LANE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_a,
   input  logic              rd_a,
   input  logic [ADDR_W-1:0] addr_a,
   input  logic [LANE_W-1:0] din_a,
   input  logic              wr_b,
   input  logic              rd_b,
   input  logic [ADDR_W-1:0] addr_b,
   input  logic [LANE_W-1:0] din_b,
   output logic [LANE_W-1:0] q_a,
   output logic              oe_a,
   output logic [LANE_W-1:0] q_b,
   output logic              oe_b
);

   localparam int unsigned DEPTH = 1 << ADDR_W;

   logic [LANE_W-1:0] store [DEPTH];

   // port a is the priority port: its write is applied last
   always_ff @(posedge clk) begin
      if (wr_b) store[addr_b] <= din_b;
      if (wr_a) store[addr_a] <= din_a;
   end

   // read-first output stage, zero when the lane is not driven
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q_a  <= '0;
         q_b  <= '0;
         oe_a <= 1'b0;
         oe_b <= 1'b0;
      end else begin
         oe_a <= rd_a;
         oe_b <= rd_b;
         q_a  <= rd_a ? store[addr_a] : '0;
         q_b  <= rd_b ? store[addr_b] : '0;
      end
   end

endmodule

// File: rtl/dpram_bytelane.sv
module dpram_bytelane
   import dpram_bytelane_pkg::*;
#(
   parameter int unsigned ADDR_W = 10,
   parameter int unsigned DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              l_ce_n,
   input  logic              l_rw,
   input  logic              l_oe_n,
   input  logic              l_ub_n,
   input  logic              l_lb_n,
   input  logic              l_sem_n,
   input  logic [ADDR_W-1:0] l_addr,
   input  logic [DATA_W-1:0] l_din,
   output logic [DATA_W-1:0] l_dout,
   output logic [1:0]        l_lane_oe,
   input  logic              r_ce_n,
   input  logic              r_rw,
   input  logic              r_oe_n,
   input  logic              r_ub_n,
   input  logic              r_lb_n,
   input  logic              r_sem_n,
   input  logic [ADDR_W-1:0] r_addr,
   input  logic [DATA_W-1:0] r_din,
   output logic [DATA_W-1:0] r_dout,
   output logic [1:0]        r_lane_oe
);

   localparam int unsigned LANE_W = DATA_W / LANES;

   if (DATA_W % LANES != 0 || DATA_W < 2) begin : g_bad_width
      $error("dpram_bytelane: DATA_W must be even and at least 2");
   end
   if (ADDR_W < 1 || ADDR_W > 20) begin : g_bad_addr
      $error("dpram_bytelane: ADDR_W out of range 1..20");
   end

   port_ctl_t l_ctl, r_ctl;

   dpram_port_decode u_dec_l (
      .ce_n (l_ce_n), .rw (l_rw), .oe_n (l_oe_n),
      .ub_n (l_ub_n), .lb_n (l_lb_n), .sem_n (l_sem_n),
      .ctl  (l_ctl)
   );

   dpram_port_decode u_dec_r (
      .ce_n (r_ce_n), .rw (r_rw), .oe_n (r_oe_n),
      .ub_n (r_ub_n), .lb_n (r_lb_n), .sem_n (r_sem_n),
      .ctl  (r_ctl)
   );

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      dpram_lane_bank #(
         .ADDR_W (ADDR_W),
         .LANE_W (LANE_W)
      ) u_bank (
         .clk    (clk),
         .rst_n  (rst_n),
         .wr_a   (l_ctl.wr[g]),
         .rd_a   (l_ctl.rd[g]),
         .addr_a (l_addr),
         .din_a  (l_din[g*LANE_W +: LANE_W]),
         .wr_b   (r_ctl.wr[g]),
         .rd_b   (r_ctl.rd[g]),
         .addr_b (r_addr),
         .din_b  (r_din[g*LANE_W +: LANE_W]),
         .q_a    (l_dout[g*LANE_W +: LANE_W]),
         .oe_a   (l_lane_oe[g]),
         .q_b    (r_dout[g*LANE_W +: LANE_W]),
         .oe_b   (r_lane_oe[g])
      );
   end

endmodule

// File: rtl/dpram_bytelane_chk.sv
module dpram_bytelane_chk #(
   parameter int unsigned DATA_W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              l_ce_n,
   input logic              l_rw,
   input logic              l_oe_n,
   input logic              l_ub_n,
   input logic              l_lb_n,
   input logic              l_sem_n,
   input logic [DATA_W-1:0] l_dout,
   input logic [1:0]        l_lane_oe,
   input logic              r_ce_n,
   input logic              r_rw,
   input logic              r_oe_n,
   input logic              r_ub_n,
   input logic              r_lb_n,
   input logic              r_sem_n,
   input logic [DATA_W-1:0] r_dout,
   input logic [1:0]        r_lane_oe
);

   localparam int unsigned LW = DATA_W / 2;

   assert_deselect_l_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (l_ce_n || (l_ub_n && l_lb_n)) |=> (l_lane_oe == 2'b00));

   assert_deselect_r_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (r_ce_n || (r_ub_n && r_lb_n)) |=> (r_lane_oe == 2'b00));

   assert_read_lanes_l_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!l_ce_n && l_sem_n && l_rw && !l_oe_n)
      |=> (l_lane_oe == ~$past({l_ub_n, l_lb_n})));

   assert_read_lanes_r_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!r_ce_n && r_sem_n && r_rw && !r_oe_n)
      |=> (r_lane_oe == ~$past({r_ub_n, r_lb_n})));

   assert_oe_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (l_rw && l_oe_n) |=> (l_lane_oe == 2'b00));

   assert_sem_blocks_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!r_sem_n) |=> (r_lane_oe == 2'b00));

   assert_quiet_lo_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!l_lane_oe[0]) |-> (l_dout[LW-1:0] == '0));

   assert_quiet_hi_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!r_lane_oe[1]) |-> (r_dout[DATA_W-1:LW] == '0));

endmodule

bind dpram_bytelane dpram_bytelane_chk #(.DATA_W(DATA_W)) u_chk (
   .clk (clk), .rst_n (rst_n),
   .l_ce_n (l_ce_n), .l_rw (l_rw), .l_oe_n (l_oe_n),
   .l_ub_n (l_ub_n), .l_lb_n (l_lb_n), .l_sem_n (l_sem_n),
   .l_dout (l_dout), .l_lane_oe (l_lane_oe),
   .r_ce_n (r_ce_n), .r_rw (r_rw), .r_oe_n (r_oe_n),
   .r_ub_n (r_ub_n), .r_lb_n (r_lb_n), .r_sem_n (r_sem_n),
   .r_dout (r_dout), .r_lane_oe (r_lane_oe)
);

// File: tb/dpram_bytelane_tb_top.sv
module dpram_bytelane_tb_top;

   localparam int unsigned AW = 10;
   localparam int unsigned DW = 16;
   localparam int unsigned DEPTH = 1 << AW;

   // control packing {ce_n, rw, oe_n, ub_n, lb_n, sem_n}
   localparam logic [5:0] C_IDLE    = 6'b111111;
   localparam logic [5:0] C_WR_BOTH = 6'b000001;
   localparam logic [5:0] C_WR_HI   = 6'b000011;
   localparam logic [5:0] C_WR_LO   = 6'b000101;
   localparam logic [5:0] C_RD_BOTH = 6'b010001;
   localparam logic [5:0] C_RD_HI   = 6'b010011;
   localparam logic [5:0] C_RD_LO   = 6'b010101;
   localparam logic [5:0] C_HIZ     = 6'b011001;
   localparam logic [5:0] C_CE_OFF  = 6'b100001;
   localparam logic [5:0] C_NO_BYTE = 6'b000111;
   localparam logic [5:0] C_RD_NOB  = 6'b010111;
   localparam logic [5:0] C_SEM_WR  = 6'b000000;
   localparam logic [5:0] C_SEM_RD  = 6'b010000;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #5 clk = ~clk;

   logic [5:0]    lc = C_IDLE, rc = C_IDLE;
   logic [AW-1:0] la = '0, ra = '0;
   logic [DW-1:0] ld = '0, rd = '0;
   logic [DW-1:0] l_dout, r_dout;
   logic [1:0]    l_lane_oe, r_lane_oe;

   int checks = 0;
   int failures = 0;

   logic [DW-1:0] model [DEPTH];

   dpram_bytelane #(.ADDR_W(AW), .DATA_W(DW)) dut_i (
      .clk (clk), .rst_n (rst_n),
      .l_ce_n (lc[5]), .l_rw (lc[4]), .l_oe_n (lc[3]),
      .l_ub_n (lc[2]), .l_lb_n (lc[1]), .l_sem_n (lc[0]),
      .l_addr (la), .l_din (ld), .l_dout (l_dout), .l_lane_oe (l_lane_oe),
      .r_ce_n (rc[5]), .r_rw (rc[4]), .r_oe_n (rc[3]),
      .r_ub_n (rc[2]), .r_lb_n (rc[1]), .r_sem_n (rc[0]),
      .r_addr (ra), .r_din (rd), .r_dout (r_dout), .r_lane_oe (r_lane_oe)
   );

   function automatic logic [1:0] rd_lanes(input logic [5:0] c);
      if (c[5] || !c[0] || !c[4] || c[3]) return 2'b00;
      return {~c[2], ~c[1]};
   endfunction

   function automatic logic [1:0] wr_lanes(input logic [5:0] c);
      if (c[5] || !c[0] || c[4]) return 2'b00;
      return {~c[2], ~c[1]};
   endfunction

   function automatic logic [DW-1:0] lane_mask(input logic [1:0] m);
      return {{(DW/2){m[1]}}, {(DW/2){m[0]}}};
   endfunction

   task automatic check(input string tag, input string side,
                        input logic [1:0] oe, input logic [DW-1:0] d,
                        input logic [1:0] eoe, input logic [DW-1:0] ed);
      checks++;
      if (oe !== eoe || d !== ed) begin
         failures++;
         $display("FAIL %s port %s: oe=%b dout=%h expected oe=%b dout=%h",
                  tag, side, oe, d, eoe, ed);
      end
   endtask

   task automatic step(input string tag,
                       input logic [5:0] c_l, input logic [AW-1:0] a_l, input logic [DW-1:0] d_l,
                       input logic [5:0] c_r, input logic [AW-1:0] a_r, input logic [DW-1:0] d_r);
      logic [1:0]    eoe_l, eoe_r, w;
      logic [DW-1:0] ed_l, ed_r, m;
      lc = c_l; la = a_l; ld = d_l;
      rc = c_r; ra = a_r; rd = d_r;
      eoe_l = rd_lanes(c_l);
      eoe_r = rd_lanes(c_r);
      ed_l  = model[a_l] & lane_mask(eoe_l);   // old contents, R8/R9
      ed_r  = model[a_r] & lane_mask(eoe_r);
      w = wr_lanes(c_r); m = lane_mask(w);
      model[a_r] = (model[a_r] & ~m) | (d_r & m);
      w = wr_lanes(c_l); m = lane_mask(w);     // left applied last, R7
      model[a_l] = (model[a_l] & ~m) | (d_l & m);
      @(negedge clk);
      check(tag, "L", l_lane_oe, l_dout, eoe_l, ed_l);
      check(tag, "R", r_lane_oe, r_dout, eoe_r, ed_r);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      void'($urandom(32'h5eed_0b17));
      foreach (model[i]) model[i] = '0;
      repeat (3) @(negedge clk);
      // R10: reset state
      check("R10", "L", l_lane_oe, l_dout, 2'b00, '0);
      check("R10", "R", r_lane_oe, r_dout, 2'b00, '0);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: fill window 0..15 from both ports, read back crosswise
      for (int i = 0; i < 8; i++)
         step("R1", C_WR_BOTH, AW'(i), 16'h1100 + 16'(i * 3),
                    C_WR_BOTH, AW'(i + 8), 16'hA000 + 16'(i * 7));
      for (int i = 0; i < 8; i++)
         step("R1", C_RD_BOTH, AW'(i + 8), '0, C_RD_BOTH, AW'(i), '0);
      // R1: top address
      step("R1", C_IDLE, '0, '0, C_WR_BOTH, AW'(DEPTH - 1), 16'hBEEF);
      step("R1", C_RD_BOTH, AW'(DEPTH - 1), '0, C_IDLE, '0, '0);

      // R3: single lane writes keep the other lane
      step("R3", C_WR_HI, 10'd2, 16'h5A5A, C_IDLE, '0, '0);
      step("R3", C_RD_BOTH, 10'd2, '0, C_WR_LO, 10'd6, 16'hC3C3);
      step("R3", C_IDLE, '0, '0, C_RD_BOTH, 10'd6, '0);
      // R4: single lane reads
      step("R4", C_RD_HI, 10'd6, '0, C_RD_LO, 10'd2, '0);

      // R7: collision on same lane, and split lanes
      step("R7", C_WR_LO, 10'd3, 16'h0011, C_WR_LO, 10'd3, 16'h0022);
      step("R7", C_RD_BOTH, 10'd3, '0, C_RD_BOTH, 10'd3, '0);
      step("R7", C_WR_HI, 10'd4, 16'h7700, C_WR_LO, 10'd4, 16'h0088);
      step("R7", C_RD_BOTH, 10'd4, '0, C_IDLE, '0, '0);
      step("R7", C_WR_BOTH, 10'd9, 16'h1234, C_WR_BOTH, 10'd9, 16'h9876);
      step("R7", C_IDLE, '0, '0, C_RD_BOTH, 10'd9, '0);

      // R8: read while the other port writes the same word
      step("R8", C_WR_BOTH, 10'd5, 16'hFACE, C_RD_BOTH, 10'd5, '0);
      step("R8", C_RD_BOTH, 10'd5, '0, C_WR_BOTH, 10'd5, 16'h0BAD);
      step("R8", C_RD_BOTH, 10'd5, '0, C_IDLE, '0, '0);

      // R2: deselected writes and reads leave memory and outputs alone
      step("R2", C_CE_OFF, 10'd7, 16'hDEAD, C_NO_BYTE, 10'd7, 16'hDEAD);
      step("R2", C_RD_NOB, 10'd7, '0, C_RD_BOTH, 10'd7, '0);
      // R5: output enable high
      step("R5", C_HIZ, 10'd7, '0, C_HIZ, 10'd1, '0);
      // R6: semaphore select blocks array
      step("R6", C_SEM_WR, 10'd1, 16'hFFFF, C_SEM_RD, 10'd1, '0);
      step("R6", C_RD_BOTH, 10'd1, '0, C_IDLE, '0, '0);

      // R4/R9: random traffic on a small window
      for (int n = 0; n < 4000; n++) begin
         logic [5:0] cl, cr;
         cl = 6'($urandom); cr = 6'($urandom);
         if ($urandom_range(3) != 0) cl[5] = 1'b0;
         if ($urandom_range(3) != 0) cr[5] = 1'b0;
         if ($urandom_range(5) != 0) cl[0] = 1'b1;
         if ($urandom_range(5) != 0) cr[0] = 1'b1;
         if ($urandom_range(3) != 0) cl[3] = 1'b0;
         if ($urandom_range(3) != 0) cr[3] = 1'b0;
         step("R4/R9", cl, AW'($urandom_range(15)), 16'($urandom),
                       cr, AW'($urandom_range(15)), 16'($urandom));
      end

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule